// File: doc/BRIEF.md
# Dual-Mode Conversion Sequencer

This block sets the timing of conversions for one or two simultaneously sampled input channels and writes the results into a FIFO. A single input pin, the conversion input, has two meanings chosen by a mode bit. In one-shot mode, a falling edge on the pin starts a short burst. During the burst, both selected channels are held together and then converted one after the other. An internal oscillator times the burst and runs only while a burst is in flight. In streaming mode, the pin is a free-running conversion clock. Each falling edge starts a conversion and each rising edge may write one result.

The analog converter is replaced by two sample ports, one per channel. A sample is taken when the block raises its hold strobe. The sample then passes through a fixed-depth latency pipeline before it reaches the FIFO write port. A change of mode or channel count clears that pipeline, so no stale result can reach the FIFO after a reconfiguration.

Top module: `conv_sequencer`

## Requirements
- R1: While reset is asserted, and right after it is released, `hold_o` and `wr_en_o` are low.
- R2: `single_mode_i`=1 selects one-shot mode and 0 selects streaming mode. `two_ch_i`=0 selects channel A only, and every write then carries `wr_ch_o`=0. `two_ch_i`=1 selects channels A and B, and writes carry `wr_ch_o`=0 for A and 1 for B.
- R3: In one-shot mode, an accepted falling edge of `conv_in_i` gives a one-cycle `hold_o` pulse exactly 3 clocks after the pin falls. Both channels are captured in that same cycle, and later changes on the sample ports do not affect the results.
- R4: In one-shot mode, the internal tick comes every `TICK_DIV` clocks after the hold. With defaults, channel A is written 27 clocks after the pin falls, and channel B 4 clocks later.
- R5: In one-shot mode, a falling edge is ignored until (channels+1) internal ticks have passed since the last accepted start: 2 ticks for one channel, 3 ticks for two. An ignored edge gives no hold and no write.
- R6: In streaming mode with one channel, each falling edge of the pin converts channel A, and a result is written only after a rising edge of the pin, 3 clocks after it. Results leave in the order they were sampled.
- R7: In streaming mode with two channels, `hold_o` pulses on every other falling edge. The falling edges alternate between converting A (taken at the hold) and converting B (taken from the same hold). Writes alternate A, B.
- R8: After reset or a reconfiguration, the first `LATENCY`-1 conversions produce no write. The sample from the first falling edge is written on the rising edge that follows the `LATENCY`-th falling edge.
- R9: A change of `single_mode_i` or `two_ch_i` drops every result still in the pipeline, and blocks writes in the following cycle.
- R10: In streaming mode, with the pin held steady, no write occurs. The internal oscillator is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_mode_i | input | 1 | 1 = one-shot, 0 = streaming |
| two_ch_i | input | 1 | 0 = channel A only, 1 = channels A and B |
| conv_in_i | input | 1 | Start strobe (one-shot) or conversion clock (streaming), asynchronous |
| samp_a_i | input | DATA_W | Converter value for channel A |
| samp_b_i | input | DATA_W | Converter value for channel B |
| hold_o | output | 1 | One-cycle strobe: selected channels captured |
| wr_en_o | output | 1 | FIFO write enable |
| wr_ch_o | output | 1 | Channel of the word being written |
| wr_data_o | output | DATA_W | Word being written |

## Verification
Every reaction to the pin first crosses two synchronizer flops and an edge register. A hold is therefore due 3 clocks after the pin changes, and a streaming write 3 clocks after a rising edge. In one-shot mode the n-th internal tick lands 3+n·`TICK_DIV` clocks after the pin falls, and a sample leaves `LATENCY` ticks after its conversion tick. The bench counts posedges, drives the pin at a negative edge, and compares the logged cycle of each write with these sums. A scoreboard queue is filled only with results whose latency window has closed. Write and hold totals are checked only after each window has fully elapsed.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    // Operating mode, as encoded on the mode input
    typedef enum logic {
        MODE_STREAM = 1'b0,
        MODE_SHOT   = 1'b1
    } seq_mode_e;

    // Number of active channels for a channel-count select value
    function automatic logic [1:0] active_channels(input logic two_ch);
        return two_ch ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/conv_seq_edge.sv
// conv_seq_edge
// Brings an asynchronous pin into the clock domain through STAGES flops,
// then flags one-cycle falling and rising events.
// Assumes the pin rests high during reset (idle start strobe), and that each
// level lasts at least two clocks.
module conv_seq_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    // Synchronizer chain plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], pin_i};
    end

    assign fall_o =  chain_q[STAGES] & ~chain_q[STAGES-1];
    assign rise_o = ~chain_q[STAGES] &  chain_q[STAGES-1];
endmodule

// File: rtl/conv_seq_osc.sv
// conv_seq_osc
// Internal conversion oscillator modelled as a divider of the system clock.
// Emits one tick every DIV clocks while enabled. A restart puts the phase back
// to zero, so the first tick comes DIV clocks later. When disabled, it holds
// still (gated off).
// Assumes DIV >= 2.
module conv_seq_osc #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = $clog2(DIV) + 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    assign tick_o = en_i && !restart_i && (phase_q == LAST);

    // Phase counter: restart, advance while enabled, otherwise frozen
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i)  phase_q <= '0;
        else if (en_i)            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/conv_seq_pipe.sv
// conv_seq_pipe
// Latency model of the converter: DEPTH stages of {valid, channel, data}.
// A shift pushes one entry in (a bubble when in_vld_i is low). An emit writes
// the oldest stage, as it was before any shift in that same cycle. A flush
// empties every stage and blocks the write.
// Assumes shift and emit are single-cycle strobes.
module conv_seq_pipe #(
    parameter int DEPTH = 5,
    parameter int DW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          shift_i,
    input  logic          emit_i,
    input  logic          in_vld_i,
    input  logic          in_ch_i,
    input  logic [DW-1:0] in_dat_i,
    output logic          wr_en_o,
    output logic          wr_ch_o,
    output logic [DW-1:0] wr_dat_o
);
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] ch_q;
    logic [DW-1:0]    dat_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            // Head stage takes the fresh conversion
            always_ff @(posedge clk) begin
                if (!rst_n || flush_i) begin
                    vld_q[i] <= 1'b0;
                    ch_q[i]  <= 1'b0;
                    dat_q[i] <= '0;
                end else if (shift_i) begin
                    vld_q[i] <= in_vld_i;
                    ch_q[i]  <= in_ch_i;
                    dat_q[i] <= in_dat_i;
                end
            end
        end else begin : g_body
            // Later stages take their predecessor
            always_ff @(posedge clk) begin
                if (!rst_n || flush_i) begin
                    vld_q[i] <= 1'b0;
                    ch_q[i]  <= 1'b0;
                    dat_q[i] <= '0;
                end else if (shift_i) begin
                    vld_q[i] <= vld_q[i-1];
                    ch_q[i]  <= ch_q[i-1];
                    dat_q[i] <= dat_q[i-1];
                end
            end
        end
    end

    // Registered FIFO write port fed by the oldest stage
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_en_o  <= 1'b0;
            wr_ch_o  <= 1'b0;
            wr_dat_o <= '0;
        end else begin
            wr_en_o <= emit_i && vld_q[DEPTH-1];
            if (emit_i && vld_q[DEPTH-1]) begin
                wr_ch_o  <= ch_q[DEPTH-1];
                wr_dat_o <= dat_q[DEPTH-1];
            end
        end
    end
endmodule

// File: rtl/conv_sequencer.sv
// conv_sequencer
// Schedules conversions for one or two channels that are sampled together.
// One-shot mode: an accepted falling edge of the conversion pin holds both
// channels, then the internal oscillator converts them in turn and flushes
// the latency pipeline. Streaming mode: the pin is the conversion clock.
// Falling edges convert, and rising edges write.
// Assumes the pin idles high, and that each pin level lasts at least two
// clocks. A change of configuration empties the pipeline.
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int LATENCY     = 5,
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_mode_i,
    input  logic              two_ch_i,
    input  logic              conv_in_i,
    input  logic [DATA_W-1:0] samp_a_i,
    input  logic [DATA_W-1:0] samp_b_i,
    output logic              hold_o,
    output logic              wr_en_o,
    output logic              wr_ch_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int RUN_W   = $clog2(LATENCY + 3) + 1;
    localparam int GUARD_W = 2;

    seq_mode_e         mode;
    logic              mode_q, two_q, cfg_chg;
    logic              pin_fall, pin_rise, tick;
    logic [1:0]        n_ch;
    logic [RUN_W-1:0]  run_left_q;
    logic [GUARD_W-1:0] guard_q;
    logic [1:0]        conv_left_q;
    logic              next_ch_q, phase_q;
    logic [DATA_W-1:0] held_a_q, held_b_q;
    logic              start_ok, stream_fall;
    logic              p_shift, p_emit, p_vld, p_ch;
    logic [DATA_W-1:0] p_dat;

    assign mode    = seq_mode_e'(single_mode_i);
    assign n_ch    = active_channels(two_ch_i);
    assign cfg_chg = (single_mode_i != mode_q) || (two_ch_i != two_q);

    conv_seq_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (conv_in_i),
        .fall_o (pin_fall),
        .rise_o (pin_rise)
    );

    assign start_ok    = (mode == MODE_SHOT) && pin_fall && (guard_q == '0) && !cfg_chg;
    assign stream_fall = (mode == MODE_STREAM) && pin_fall && !cfg_chg;

    conv_seq_osc #(.DIV(TICK_DIV)) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      ((mode == MODE_SHOT) && (run_left_q != '0) && !cfg_chg),
        .restart_i (start_ok),
        .tick_o    (tick)
    );

    // Remember the configuration to detect changes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            two_q  <= 1'b0;
        end else begin
            mode_q <= single_mode_i;
            two_q  <= two_ch_i;
        end
    end

    // Start spacing guard, counted in internal ticks
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_chg)         guard_q <= '0;
        else if (start_ok)             guard_q <= GUARD_W'(n_ch) + 1'b1;
        else if (tick && guard_q != 0) guard_q <= guard_q - 1'b1;
    end

    // Burst length: conversions plus pipeline flush, in ticks
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_chg)            run_left_q <= '0;
        else if (start_ok)                run_left_q <= RUN_W'(LATENCY) + RUN_W'(n_ch);
        else if (tick && run_left_q != 0) run_left_q <= run_left_q - 1'b1;
    end

    // Conversions still owed in the current burst, and which channel is next
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_chg) begin
            conv_left_q <= '0;
            next_ch_q   <= 1'b0;
        end else if (start_ok) begin
            conv_left_q <= n_ch;
            next_ch_q   <= 1'b0;
        end else if (tick && conv_left_q != 0) begin
            conv_left_q <= conv_left_q - 1'b1;
            next_ch_q   <= 1'b1;
        end
    end

    // Streaming channel phase: 0 = hold and convert A, 1 = convert held B
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_chg) phase_q <= 1'b0;
        else if (stream_fall)  phase_q <= two_ch_i ? ~phase_q : 1'b0;
    end

    // Sample-and-hold registers for both channels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_a_q <= '0;
            held_b_q <= '0;
        end else if (start_ok) begin
            held_a_q <= samp_a_i;
            held_b_q <= samp_b_i;
        end else if (stream_fall && !phase_q) begin
            held_b_q <= samp_b_i;
        end
    end

    // Hold strobe for every capture
    always_ff @(posedge clk) begin
        if (!rst_n) hold_o <= 1'b0;
        else        hold_o <= start_ok || (stream_fall && !phase_q);
    end

    // Pipeline control depends on the mode
    always_comb begin
        if (mode == MODE_SHOT) begin
            p_shift = tick;
            p_emit  = tick;
            p_vld   = (conv_left_q != 0);
            p_ch    = next_ch_q;
            p_dat   = next_ch_q ? held_b_q : held_a_q;
        end else begin
            p_shift = stream_fall;
            p_emit  = pin_rise;
            p_vld   = 1'b1;
            p_ch    = phase_q;
            p_dat   = phase_q ? held_b_q : samp_a_i;
        end
    end

    conv_seq_pipe #(.DEPTH(LATENCY), .DW(DATA_W)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (cfg_chg),
        .shift_i  (p_shift),
        .emit_i   (p_emit),
        .in_vld_i (p_vld),
        .in_ch_i  (p_ch),
        .in_dat_i (p_dat),
        .wr_en_o  (wr_en_o),
        .wr_ch_o  (wr_ch_o),
        .wr_dat_o (wr_data_o)
    );
endmodule

// File: rtl/conv_sequencer_chk.sv
// conv_sequencer_chk
// Properties checked on the sequencer ports. Bound to every instance.
module conv_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic single_mode_i,
    input logic two_ch_i,
    input logic hold_o,
    input logic wr_en_o,
    input logic wr_ch_o
);
    // R9: a configuration change blocks the next write
    a_r9_cfg_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ((single_mode_i != $past(single_mode_i)) || (two_ch_i != $past(two_ch_i))) |=> !wr_en_o);

    // R3: the hold strobe lasts one cycle
    a_r3_hold_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> !hold_o);

    // R4: writes never come in back-to-back cycles
    a_r4_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R2: with one channel only channel A is written
    a_r2_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !two_ch_i && !$past(two_ch_i)) |-> !wr_ch_o);
endmodule

bind conv_sequencer conv_sequencer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .single_mode_i (single_mode_i),
    .two_ch_i      (two_ch_i),
    .hold_o        (hold_o),
    .wr_en_o       (wr_en_o),
    .wr_ch_o       (wr_ch_o)
);

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
    localparam int DW  = 10;
    localparam int LAT = 5;
    localparam int DIV = 4;
    localparam int HP  = 6;

    logic clk = 1'b0;
    logic rst_n, single_mode, two_ch, conv_in;
    logic [DW-1:0] samp_a, samp_b;
    logic hold, wr_en, wr_ch;
    logic [DW-1:0] wr_data;

    always #2 clk = ~clk;

    conv_sequencer #(.DATA_W(DW), .LATENCY(LAT), .TICK_DIV(DIV)) u_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .single_mode_i(single_mode), .two_ch_i(two_ch),
        .conv_in_i(conv_in), .samp_a_i(samp_a), .samp_b_i(samp_b),
        .hold_o(hold), .wr_en_o(wr_en), .wr_ch_o(wr_ch), .wr_data_o(wr_data)
    );

    int checks = 0, failures = 0, cyc = 0, wr_cnt = 0, hold_cnt = 0, falls = 0;
    bit done = 0;
    string tag = "R6";
    logic [DW:0] expq[$];
    int wr_log[$];
    logic [DW-1:0] hist_a [64];
    logic [DW-1:0] hist_b [64];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: counts holds, pops and compares every write
    always @(negedge clk) begin
        if (rst_n && hold) hold_cnt++;
        if (rst_n && wr_en) begin
            wr_cnt++;
            wr_log.push_back(cyc);
            if (expq.size() == 0) chk(0, {tag, " unexpected write"}, int'({wr_ch, wr_data}), -1);
            else begin
                logic [DW:0] e;
                e = expq.pop_front();
                chk({wr_ch, wr_data} == e, {tag, " write ch/data"}, int'({wr_ch, wr_data}), int'(e));
            end
        end
    end

    // One streaming period: fall, hold HP, rise, hold HP
    task automatic stream_period(input logic [DW-1:0] a, input logic [DW-1:0] b);
        int k;
        @(negedge clk);
        falls++;
        samp_a = a; samp_b = b;
        hist_a[falls] = a; hist_b[falls] = b;
        conv_in = 1'b0;
        k = falls - LAT + 1;
        if (k >= 1) begin
            if (!two_ch) expq.push_back({1'b0, hist_a[k]});
            else if (k % 2 == 1) expq.push_back({1'b0, hist_a[k]});
            else expq.push_back({1'b1, hist_b[k-1]});
        end
        repeat (HP) @(negedge clk);
        conv_in = 1'b1;
        repeat (HP - 1) @(negedge clk);
    endtask

    // One-shot start: returns the cycle count when the pin fell
    task automatic shot(input logic [DW-1:0] a, input logic [DW-1:0] b, input int low, output int c);
        @(negedge clk);
        samp_a = a; samp_b = b;
        conv_in = 1'b0;
        c = cyc;
        repeat (low) @(negedge clk);
        conv_in = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c, w0, h0;
        rst_n = 1'b0; single_mode = 1'b0; two_ch = 1'b0; conv_in = 1'b1;
        samp_a = '0; samp_b = '0;
        repeat (5) @(negedge clk);
        chk(hold == 1'b0, "R1 hold in reset", hold, 0);
        chk(wr_en == 1'b0, "R1 wr_en in reset", wr_en, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(hold == 1'b0 && wr_en == 1'b0, "R1 after reset", {hold, wr_en}, 0);

        // Streaming, one channel: latency
        tag = "R6";
        for (int p = 1; p <= 4; p++) stream_period(DW'(10'h100 + p), DW'(10'h3F0));
        chk(wr_cnt == 0, "R8 no write before latency", wr_cnt, 0);
        stream_period(DW'(10'h105), DW'(10'h3F0));
        chk(wr_cnt == 1, "R8 first write after latency", wr_cnt, 1);
        for (int p = 6; p <= 8; p++) stream_period(DW'(10'h100 + p), DW'(10'h3F0));
        chk(wr_cnt == 4, "R6 one write per period", wr_cnt, 4);
        repeat (30) @(negedge clk);
        chk(wr_cnt == 4, "R10 idle pin gives no write", wr_cnt, 4);

        // Reconfigure to two channels: pending results dropped
        two_ch = 1'b1;
        repeat (20) @(negedge clk);
        chk(wr_cnt == 4, "R9 flush on channel change", wr_cnt, 4);
        falls = 0; tag = "R7"; h0 = hold_cnt;
        for (int p = 1; p <= 10; p++) begin
            if (p % 2 == 1) stream_period(DW'(10'h200 + p), DW'(10'h280 + p));
            else            stream_period(DW'(10'h011), DW'(10'h022));
        end
        chk(wr_cnt == 10, "R7 two-channel writes", wr_cnt, 10);
        chk(hold_cnt - h0 == 5, "R7 hold every other fall", hold_cnt - h0, 5);
        chk(expq.size() == 0, "R7 queue drained", expq.size(), 0);

        // One-shot, one channel
        single_mode = 1'b1; two_ch = 1'b0; tag = "R3";
        repeat (20) @(negedge clk);
        chk(wr_cnt == 10, "R9 flush on mode change", wr_cnt, 10);
        wr_log.delete(); h0 = hold_cnt;
        expq.push_back({1'b0, DW'(10'h0AA)});
        shot(DW'(10'h0AA), DW'(10'h055), 8, c);
        repeat (45) @(negedge clk);
        chk(wr_log.size() == 1, "R4 one write for one channel", wr_log.size(), 1);
        if (wr_log.size() > 0)
            chk(wr_log[0] == c + 3 + (LAT + 1) * DIV, "R4 write timing ch A", wr_log[0], c + 3 + (LAT + 1) * DIV);
        chk(hold_cnt - h0 == 1, "R3 one hold per start", hold_cnt - h0, 1);

        // Start too soon after the previous one is ignored
        w0 = wr_cnt; h0 = hold_cnt;
        expq.push_back({1'b0, DW'(10'h0C3)});
        shot(DW'(10'h0C3), DW'(10'h0C4), 3, c);
        repeat (3) @(negedge clk);
        samp_a = DW'(10'h3C3);
        conv_in = 1'b0;
        repeat (3) @(negedge clk);
        conv_in = 1'b1;
        repeat (50) @(negedge clk);
        chk(wr_cnt - w0 == 1, "R5 early start ignored (writes)", wr_cnt - w0, 1);
        chk(hold_cnt - h0 == 1, "R5 early start ignored (holds)", hold_cnt - h0, 1);

        // One-shot, two channels: simultaneous capture and timing
        two_ch = 1'b1;
        repeat (10) @(negedge clk);
        wr_log.delete();
        expq.push_back({1'b0, DW'(10'h111)});
        expq.push_back({1'b1, DW'(10'h222)});
        shot(DW'(10'h111), DW'(10'h222), 10, c);
        samp_a = DW'(10'h3FF); samp_b = DW'(10'h3FE);
        repeat (50) @(negedge clk);
        chk(wr_log.size() == 2, "R3 two writes per start", wr_log.size(), 2);
        if (wr_log.size() == 2) begin
            chk(wr_log[0] == c + 3 + (LAT + 1) * DIV, "R4 timing ch A", wr_log[0], c + 3 + (LAT + 1) * DIV);
            chk(wr_log[1] == c + 3 + (LAT + 2) * DIV, "R4 timing ch B", wr_log[1], c + 3 + (LAT + 2) * DIV);
        end

        // Starts spaced beyond the guard are both accepted
        w0 = wr_cnt; h0 = hold_cnt;
        expq.push_back({1'b0, DW'(10'h131)});
        expq.push_back({1'b1, DW'(10'h132)});
        expq.push_back({1'b0, DW'(10'h141)});
        expq.push_back({1'b1, DW'(10'h142)});
        shot(DW'(10'h131), DW'(10'h132), 8, c);
        repeat (6) @(negedge clk);
        shot(DW'(10'h141), DW'(10'h142), 8, c);
        repeat (70) @(negedge clk);
        chk(wr_cnt - w0 == 4, "R5 spaced starts accepted", wr_cnt - w0, 4);
        chk(hold_cnt - h0 == 2, "R5 two holds", hold_cnt - h0, 2);
        chk(expq.size() == 0, "R2 all results delivered", expq.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule